// File: doc/BRIEF.md
# Card Presence and Fault Alert Controller

This block drives one active-low alert line toward a host controller and issues a one-cycle request that starts card power-down in an external sequencer. The host marks a card session by pulling its session command input low. Outside a session the alert line is a plain card-present indicator: high with a card inserted, low without one. Inside a session the same line becomes an alarm. It is pulled low when the card is pulled out or when any fault flag is raised (undervoltage, overcurrent, overheating and similar). It then stays low until the host ends the session.

The card-present signal and the fault flags come from other clock domains. Each passes through a two-stage synchronizer before the state machine sees it. The session command comes from the host in this clock domain and is used as it arrives. The machine has three states:

- OUTSIDE: no session is active.
- ARMED: a session is running and the card is healthy.
- ALARM: a session is running and the alarm is latched.

The transitions are:

- START_OK: OUTSIDE to ARMED, when the session begins with a card present and no fault.
- START_BAD: OUTSIDE to ALARM, when the session begins with no card or with a fault.
- TRIP: ARMED to ALARM, on extraction or a fault.
- END: ARMED or ALARM to OUTSIDE, when the session command goes high.

Top module: `card_alert`

## Requirements
- R1: A session exists only while `sess_cmd_n` is low. A change on `sess_cmd_n` takes effect on the state at the next rising clock edge.
- R2: Outside a session, `irq_n` equals `card_present` as seen through two synchronizer flops. An input change shows on `irq_n` after the second rising edge.
- R3: Outside a session, the fault flags have no effect on `irq_n`, and `deact_start` stays 0.
- R4: Inside a session, either of two events drives `irq_n` low: the synchronized `card_present` is 0, or any synchronized fault bit is 1. The line goes low three rising edges after the input change.
- R5: `deact_start` is 1 in exactly the cycle in which `irq_n` first goes low for an in-session alarm.
- R6: Once the alarm is raised in a session, `irq_n` stays low until `sess_cmd_n` returns high. This holds even when faults clear or the card returns.
- R7: `deact_start` is a single-cycle pulse. It fires once per alarm and never again while the alarm is latched.
- R8: A session started with no card present, or with a fault present, moves straight to ALARM. `irq_n` goes low and `deact_start` pulses at the first edge after `sess_cmd_n` falls.
- R9: Synchronous reset `rst` (active high) clears the synchronizers and puts the block OUTSIDE with no alarm. During reset `irq_n` is 0 and `deact_start` is 0.
- R10: When the session ends, the line follows presence again from the next edge. A later session can raise a new alarm with a new pulse.
- R11: When the session ends on the same edge that a fault would trip the alarm, the release wins: no `deact_start` pulse is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sess_cmd_n | input | 1 | Session command, low while a card session is active |
| card_present | input | 1 | Debounced card-present signal, asynchronous |
| fault_flags | input | NUM_FAULTS | Fault flags, 1 means fault, asynchronous |
| irq_n | output | 1 | Active-low alert line toward the host |
| deact_start | output | 1 | One-cycle deactivation start pulse |

## Verification
The bench goes after the following corner cases:

- A session opened with no card. A design that waits for an ARMED cycle first would delay the pulse by one cycle.
- A fault that clears one cycle after it trips. A design without the latch would let the line rise again or pulse a second time.
- A fault raised outside a session. A design that ignores the session state would pull the line low or request power-down.
- A session ending on the same edge as a fault. A design with the wrong priority would emit a stray pulse.

Random session, presence and fault activity is also checked every cycle against a bench model of the synchronizer latency.

// File: rtl/card_alert_pkg.sv
package card_alert_pkg;

    typedef enum logic [1:0] {
        ST_OUTSIDE = 2'd0,
        ST_ARMED   = 2'd1,
        ST_ALARM   = 2'd2
    } alert_state_t;

endpackage

// File: rtl/card_alert_sync.sv
module card_alert_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d_async;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/card_alert_fsm.sv
module card_alert_fsm
    import card_alert_pkg::*;
#(
    parameter int NUM_FAULTS = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sess_cmd_n,
    input  logic                  pres_s,
    input  logic [NUM_FAULTS-1:0] fault_s,
    output alert_state_t          state,
    output logic                  irq_n,
    output logic                  deact_start
);
    alert_state_t state_q, state_d;
    logic         bad_now;
    logic         trip;
    logic         pulse_q;

    assign bad_now = !pres_s || (|fault_s);

    // next-state logic: session release has priority over any trip
    always_comb begin
        state_d = state_q;
        trip    = 1'b0;
        unique case (state_q)
            ST_OUTSIDE: begin
                if (!sess_cmd_n) begin
                    if (bad_now) begin
                        state_d = ST_ALARM;   // START_BAD
                        trip    = 1'b1;
                    end else begin
                        state_d = ST_ARMED;   // START_OK
                    end
                end
            end
            ST_ARMED: begin
                if (sess_cmd_n) begin
                    state_d = ST_OUTSIDE;     // END
                end else if (bad_now) begin
                    state_d = ST_ALARM;       // TRIP
                    trip    = 1'b1;
                end
            end
            ST_ALARM: begin
                if (sess_cmd_n) state_d = ST_OUTSIDE; // END
            end
            default: state_d = ST_OUTSIDE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OUTSIDE;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= trip;
        end
    end

    // outputs
    always_comb begin
        irq_n = 1'b0;
        unique case (state_q)
            ST_OUTSIDE: irq_n = pres_s;
            ST_ARMED:   irq_n = 1'b1;
            ST_ALARM:   irq_n = 1'b0;
            default:    irq_n = 1'b0;
        endcase
    end

    assign deact_start = pulse_q;
    assign state       = state_q;
endmodule

// File: rtl/card_alert.sv
module card_alert
    import card_alert_pkg::*;
#(
    parameter int NUM_FAULTS  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sess_cmd_n,
    input  logic                  card_present,
    input  logic [NUM_FAULTS-1:0] fault_flags,
    output logic                  irq_n,
    output logic                  deact_start
);
    localparam int SYNC_W = NUM_FAULTS + 1;

    logic [SYNC_W-1:0]     raw_in;
    logic [SYNC_W-1:0]     synced;
    logic                  pres_s;
    logic [NUM_FAULTS-1:0] fault_s;
    alert_state_t          state;

    assign raw_in  = {fault_flags, card_present};
    assign pres_s  = synced[0];
    assign fault_s = synced[SYNC_W-1:1];

    card_alert_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw_in),
        .q_sync  (synced)
    );

    card_alert_fsm #(
        .NUM_FAULTS (NUM_FAULTS)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sess_cmd_n  (sess_cmd_n),
        .pres_s      (pres_s),
        .fault_s     (fault_s),
        .state       (state),
        .irq_n       (irq_n),
        .deact_start (deact_start)
    );
endmodule

// File: rtl/card_alert_chk.sv
module card_alert_chk (
    input logic clk,
    input logic rst,
    input logic sess_cmd_n,
    input logic irq_n,
    input logic deact_start
);
    // R5: the pulse coincides with a low alert line
    a_r5_pulse_with_low_line: assert property (@(posedge clk) disable iff (rst)
        deact_start |-> !irq_n);

    // R7: the pulse never lasts two cycles
    a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
        deact_start |=> !deact_start);

    // R3: no pulse while outside a session on consecutive edges
    a_r3_no_pulse_outside: assert property (@(posedge clk) disable iff (rst)
        (sess_cmd_n && $past(sess_cmd_n)) |-> !deact_start);

    // R6: a low line stays low while the session continues
    a_r6_latched_low: assert property (@(posedge clk) disable iff (rst)
        (!sess_cmd_n && $past(!sess_cmd_n) && $past(!irq_n)) |-> !irq_n);

    // R1: a pulse only follows an edge at which the session was active
    a_r1_pulse_needs_session: assert property (@(posedge clk) disable iff (rst)
        deact_start |-> !$past(sess_cmd_n));
endmodule

bind card_alert card_alert_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sess_cmd_n  (sess_cmd_n),
    .irq_n       (irq_n),
    .deact_start (deact_start)
);

// File: tb/card_alert_test.sv
module card_alert_test;
    localparam int NF = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sess_cmd_n = 1'b1;
    logic          card_present = 1'b0;
    logic [NF-1:0] fault_flags = '0;
    logic          irq_n;
    logic          deact_start;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic          m_p1, m_p2;
    logic [NF-1:0] m_f1, m_f2;
    logic          m_in, m_alarm, m_deact;

    always #4 clk = ~clk;

    card_alert #(.NUM_FAULTS(NF), .SYNC_STAGES(2)) uut (
        .clk          (clk),
        .rst          (rst),
        .sess_cmd_n   (sess_cmd_n),
        .card_present (card_present),
        .fault_flags  (fault_flags),
        .irq_n        (irq_n),
        .deact_start  (deact_start)
    );

    function automatic logic exp_irq(input logic insess, input logic alarm, input logic p2);
        return insess ? !alarm : p2;
    endfunction

    function automatic logic is_bad(input logic p2, input logic [NF-1:0] f2);
        return !p2 || (|f2);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_p1 <= 0; m_p2 <= 0; m_f1 <= '0; m_f2 <= '0;
            m_in <= 0; m_alarm <= 0; m_deact <= 0;
        end else begin
            m_p1 <= card_present; m_p2 <= m_p1;
            m_f1 <= fault_flags;  m_f2 <= m_f1;
            if (sess_cmd_n) begin
                m_in <= 0; m_alarm <= 0; m_deact <= 0;
            end else if (!m_alarm && is_bad(m_p2, m_f2)) begin
                m_in <= 1; m_alarm <= 1; m_deact <= 1;
            end else begin
                m_in <= 1; m_deact <= 0;
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // sample at negedge, compare both outputs to the model
    task automatic tick(input string tag_irq, input string tag_pulse);
        @(negedge clk);
        check(tag_irq, irq_n, exp_irq(m_in, m_alarm, m_p2));
        check(tag_pulse, deact_start, m_deact);
    endtask

    task automatic run(input int n, input string ti, input string tp);
        for (int i = 0; i < n; i++) tick(ti, tp);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int unsigned r;
        r = $urandom(32'h1F2E3D);
        // R9 reset state
        run(3, "R9 reset irq", "R9 reset pulse");
        @(negedge clk);
        check("R9 irq low in reset", irq_n, 1'b0);
        check("R9 no pulse in reset", deact_start, 1'b0);
        rst = 1'b0;
        card_present = 1'b1;
        tick("R9 after reset", "R9 after reset pulse");
        check("R2 not yet visible after 1 edge", irq_n, 1'b0);
        tick("R2 presence", "R3 pulse");
        check("R2 visible after 2 edges", irq_n, 1'b1);

        // R3 fault outside session
        fault_flags = 3'b010;
        run(4, "R3 fault outside irq", "R3 fault outside pulse");
        check("R3 line high despite fault", irq_n, 1'b1);
        fault_flags = '0;
        run(3, "R3 irq", "R3 pulse");

        // R1/R4/R5/R6/R7 trip then transient clear
        sess_cmd_n = 1'b0;
        run(3, "R1 session armed", "R1 pulse");
        check("R1 armed line high", irq_n, 1'b1);
        fault_flags = 3'b100;
        tick("R4 fault", "R5 pulse");
        fault_flags = '0;
        tick("R4 fault", "R5 pulse");
        tick("R4 trip irq", "R5 trip pulse");
        check("R4 line low after 3 edges", irq_n, 1'b0);
        check("R5 pulse with trip", deact_start, 1'b1);
        tick("R6 latch irq", "R7 pulse once");
        check("R7 pulse one cycle", deact_start, 1'b0);
        run(5, "R6 latched after clear", "R7 no retrigger");
        check("R6 still low after fault cleared", irq_n, 1'b0);

        // R10 release, presence follows
        sess_cmd_n = 1'b1;
        tick("R10 release irq", "R10 release pulse");
        check("R10 line follows presence", irq_n, 1'b1);

        // R8 session started with no card
        card_present = 1'b0;
        run(3, "R2 removal outside", "R3 pulse");
        sess_cmd_n = 1'b0;
        tick("R8 start bad irq", "R8 start bad pulse");
        check("R8 low at first edge", irq_n, 1'b0);
        check("R8 pulse at first edge", deact_start, 1'b1);
        card_present = 1'b1;
        run(4, "R6 card back still low", "R7 no retrigger");
        sess_cmd_n = 1'b1;
        run(2, "R10 release", "R10 pulse");

        // R11 release on the same edge as a trip
        sess_cmd_n = 1'b0;
        run(3, "R1 armed again", "R1 pulse");
        fault_flags = 3'b001;
        run(2, "R11 pre", "R11 pre pulse");
        sess_cmd_n = 1'b1;
        tick("R11 release wins irq", "R11 no pulse");
        check("R11 no pulse on release", deact_start, 1'b0);
        fault_flags = '0;
        run(3, "R3 irq", "R3 pulse");

        // extraction in session (R4) then a new session alarm (R10)
        sess_cmd_n = 1'b0;
        run(3, "R1 armed", "R1 pulse");
        card_present = 1'b0;
        run(3, "R4 extraction", "R5 extraction pulse");
        check("R4 extraction low", irq_n, 1'b0);
        check("R5 extraction pulse", deact_start, 1'b1);
        sess_cmd_n = 1'b1;
        card_present = 1'b1;
        run(3, "R10 irq", "R10 pulse");

        // random phase
        for (int c = 0; c < 4000; c++) begin
            r = $urandom;
            if (r[3:0] == 0) sess_cmd_n = ~sess_cmd_n;
            if (r[9:5] == 0) card_present = ~card_present;
            fault_flags = (r[15:11] == 0) ? NF'(r[20:18]) : '0;
            if (m_in) tick("R4 R6 random in session", "R5 R7 random pulse");
            else      tick("R2 R3 random outside", "R3 random pulse");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule